// File: doc/BRIEF.md
# Free-Running Capture/Compare Timer

This block is a 16-bit up-counter that runs freely from zero and carries two channels. Each channel is switched by software between compare duty and capture duty. As a comparator it watches the counter, raises its own interrupt pulse and flips its output pin when the count reaches the stored value. As a capture unit it copies the counter into its register when a chosen edge arrives on its trigger pin.

The count advances either on an internal prescaled enable (`tickIn`) or on selected edges of event pin 0. Event pin 0 is at the same time the capture trigger for channel 0, with its own edge setting. Event pin 1 triggers channel 1. Both pins pass through two-flop synchronizers. A wrap from 16'hFFFF to 16'h0000 raises a one-cycle overflow pulse.

Software drives the block through a write port and a combinational read port. Address 0 is control (bit 0 enables counting). Address 1 holds the mode (bits 2:0). Address 2 holds the channel configuration. Addresses 3 and 4 are the channel 0 and channel 1 registers.

Top module: `cc_timer`

## Requirements
- R1: After reset the counter is 0, all outputs and interrupt pulses are low, and every readable register reads 0.
- R2: The counter advances only while the mode field reads 3'b101 and the enable bit is 1. Otherwise it is held at 0 and no overflow or channel interrupt is raised.
- R3: Clearing the enable bit returns the counter to 0. Setting it again restarts the count from 0.
- R4: A count step from 16'hFFFF to 16'h0000 raises `irqOvf` for exactly one cycle, in the cycle after the edge that made the step.
- R5: A channel in compare mode raises its interrupt for one cycle and toggles its output pin on the count step that brings the counter equal to its register. With `tickIn` held high and counting enabled at edge 0, value V (including 0, reached at the wrap) matches at edge V.
- R6: A channel in capture mode stores the counter and pulses its interrupt 3 clock edges after a qualifying pin change is first sampled. The stored value is the counter value 2 cycles after that sampling.
- R7: Each edge setting is 2 bits: 00 means no edge, 01 rising, 10 falling, 11 both edges.
- R8: Config bit 2 = 1 makes the counter step on the edges of event pin 0 selected by config bits 4:3, and `tickIn` is then ignored. Bit 2 = 0 makes it step on every cycle with `tickIn` high.
- R9: Event pin 0 triggers channel 0 capture through its own edge setting (config bits 6:5), independent of the count edge setting. Event pin 1 triggers channel 1 through config bits 8:7.
- R10: Config bit 0 (channel 0) and bit 1 (channel 1) select capture when 1 and compare when 0. A capture channel never toggles its output, and a compare channel ignores its trigger pin.
- R11: Reads return enable at address 0 bit 0, mode at address 1 bits 2:0, the 9-bit configuration at address 2, and the channel registers at addresses 3 and 4. Writes to addresses 3 and 4 load the channel registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 16 | Read data (combinational) |
| tickIn | input | 1 | Internal count enable |
| evtPin0 | input | 1 | Event count input and channel 0 capture trigger |
| evtPin1 | input | 1 | Channel 1 capture trigger |
| outPin0 | output | 1 | Channel 0 toggle output |
| outPin1 | output | 1 | Channel 1 toggle output |
| irqOvf | output | 1 | Overflow interrupt pulse |
| irqCc0 | output | 1 | Channel 0 match/capture pulse |
| irqCc1 | output | 1 | Channel 1 match/capture pulse |

## Verification
The counter reads 1 one edge after the enable write lands, so a compare value V is due V edges after that write. A pin change made after edge N is captured as N+2, with the interrupt seen after edge N+3. The overflow pulse is due 65536 edges after enabling. The bench drives every input at a falling edge and counts falling edges from the enabling write. It samples each result at the falling edge numbered by these latencies and checks that the pulse is absent in the cycles around it.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;
  localparam int ADDR_W = 3;
  localparam int CFG_W  = 9;
  localparam logic [2:0] MODE_FREE = 3'b101;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CC0  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CC1  = 3'd4;

  // channel configuration word, MSB first
  typedef struct packed {
    logic [1:0] trig1Edge;
    logic [1:0] trig0Edge;
    logic [1:0] cntEdge;
    logic       extCount;
    logic       cap1Sel;
    logic       cap0Sel;
  } tmrCfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;
    logic step;
    logic cap0;
    logic cap1;
    logic cmp0;
    logic cmp1;
    logic ld0;
    logic ld1;
  } tmrStrobe_t;

  function automatic logic edgeHit(input logic [1:0] sel, input logic rise, input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction
endpackage

// File: rtl/cc_timer_edge.sv
module cc_timer_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic rise,
  output logic fall
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rise = syncQ[SYNC_STAGES-1] & ~prevQ;
  assign fall = ~syncQ[SYNC_STAGES-1] & prevQ;
endmodule

// File: rtl/cc_timer_ctrl.sv
module cc_timer_ctrl
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              tickIn,
  input  logic              evtPin0,
  input  logic              evtPin1,
  input  logic [CNT_W-1:0]  ccVal0,
  input  logic [CNT_W-1:0]  ccVal1,
  output tmrCfg_t           cfg,
  output tmrStrobe_t        strb
);
  localparam int NUM_PINS = 2;

  logic       enableQ;
  logic [2:0] modeQ;
  tmrCfg_t    cfgQ;

  logic [NUM_PINS-1:0] pinRaw;
  logic [NUM_PINS-1:0] pinRise;
  logic [NUM_PINS-1:0] pinFall;

  assign pinRaw = {evtPin1, evtPin0};

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    cc_timer_edge #(.SYNC_STAGES(2)) uEdge (
      .clk  (clk),
      .rstN (rstN),
      .pinIn(pinRaw[g]),
      .rise (pinRise[g]),
      .fall (pinFall[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      modeQ   <= '0;
      cfgQ    <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: enableQ <= wrData[0];
        ADDR_MODE: modeQ   <= wrData[2:0];
        ADDR_CFG:  cfgQ    <= tmrCfg_t'(wrData[CFG_W-1:0]);
        default: ;
      endcase
    end
  end

  logic runNow;
  assign runNow = enableQ && (modeQ == MODE_FREE);

  always_comb begin
    strb.run  = runNow;
    strb.step = cfgQ.extCount ? edgeHit(cfgQ.cntEdge, pinRise[0], pinFall[0]) : tickIn;
    strb.cap0 = runNow && cfgQ.cap0Sel && edgeHit(cfgQ.trig0Edge, pinRise[0], pinFall[0]);
    strb.cap1 = runNow && cfgQ.cap1Sel && edgeHit(cfgQ.trig1Edge, pinRise[1], pinFall[1]);
    strb.cmp0 = !cfgQ.cap0Sel;
    strb.cmp1 = !cfgQ.cap1Sel;
    strb.ld0  = wrEn && (wrAddr == ADDR_CC0);
    strb.ld1  = wrEn && (wrAddr == ADDR_CC1);
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_CTRL: rdData[0]         = enableQ;
      ADDR_MODE: rdData[2:0]       = modeQ;
      ADDR_CFG:  rdData[CFG_W-1:0] = cfgQ;
      ADDR_CC0:  rdData            = ccVal0;
      ADDR_CC1:  rdData            = ccVal1;
      default:   rdData            = '0;
    endcase
  end

  assign cfg = cfgQ;
endmodule

// File: rtl/cc_timer_dp.sv
module cc_timer_dp
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] ccVal0,
  output logic [CNT_W-1:0] ccVal1,
  output logic             outPin0,
  output logic             outPin1,
  output logic             irqOvf,
  output logic             irqCc0,
  output logic             irqCc1
);
  localparam int NUM_CH = 2;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic             advance;

  assign cntNext = cnt + 1'b1;
  assign advance = strb.run && strb.step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      irqOvf <= 1'b0;
    end else begin
      irqOvf <= advance && (cnt == CNT_TOP);
      if (!strb.run)    cnt <= '0;
      else if (advance) cnt <= cntNext;
    end
  end

  logic [NUM_CH-1:0] capHit, cmpOn, ldHit;
  logic [CNT_W-1:0]  ccReg [NUM_CH];
  logic [NUM_CH-1:0] outQ, irqQ;

  assign capHit = {strb.cap1, strb.cap0};
  assign cmpOn  = {strb.cmp1, strb.cmp0};
  assign ldHit  = {strb.ld1,  strb.ld0};

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ccReg[g] <= '0;
        outQ[g]  <= 1'b0;
        irqQ[g]  <= 1'b0;
      end else begin
        irqQ[g] <= 1'b0;
        // a capture takes priority over a software load
        if (capHit[g]) begin
          ccReg[g] <= cnt;
          irqQ[g]  <= 1'b1;
        end else if (ldHit[g]) begin
          ccReg[g] <= wrData;
        end
        if (cmpOn[g] && advance && (cntNext == ccReg[g])) begin
          irqQ[g] <= 1'b1;
          outQ[g] <= ~outQ[g];
        end
      end
    end
  end

  assign ccVal0  = ccReg[0];
  assign ccVal1  = ccReg[1];
  assign outPin0 = outQ[0];
  assign outPin1 = outQ[1];
  assign irqCc0  = irqQ[0];
  assign irqCc1  = irqQ[1];
endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  input  logic              tickIn,
  input  logic              evtPin0,
  input  logic              evtPin1,
  output logic              outPin0,
  output logic              outPin1,
  output logic              irqOvf,
  output logic              irqCc0,
  output logic              irqCc1
);
  tmrStrobe_t       strb;
  tmrCfg_t          cfg;
  logic [CNT_W-1:0] ccVal0, ccVal1;

  cc_timer_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .tickIn(tickIn), .evtPin0(evtPin0), .evtPin1(evtPin1),
    .ccVal0(ccVal0), .ccVal1(ccVal1),
    .cfg(cfg), .strb(strb)
  );

  cc_timer_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN),
    .strb(strb), .wrData(wrData),
    .ccVal0(ccVal0), .ccVal1(ccVal1),
    .outPin0(outPin0), .outPin1(outPin1),
    .irqOvf(irqOvf), .irqCc0(irqCc0), .irqCc1(irqCc1)
  );
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk
  import cc_timer_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input logic    run,
  input tmrCfg_t cfg,
  input logic    outPin0,
  input logic    outPin1,
  input logic    irqOvf,
  input logic    irqCc0,
  input logic    irqCc1
);
  // R4: overflow pulse lasts one cycle
  a_r4_ovf_single: assert property (@(posedge clk) disable iff (!rstN)
    irqOvf |=> !irqOvf);

  // R2: nothing fires unless the counter was running
  a_r2_no_ovf_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(run) |-> !irqOvf);

  a_r2_no_cc_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$past(run) |-> (!irqCc0 && !irqCc1));

  // R5: an output toggle always comes with the channel interrupt
  a_r5_toggle_has_irq: assert property (@(posedge clk) disable iff (!rstN)
    (outPin0 != $past(outPin0)) |-> irqCc0);

  // R10: a capture channel keeps its output still
  a_r10_cap_out_still: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfg.cap1Sel) |-> $stable(outPin1));

  // R7: edge setting 00 never triggers a capture
  a_r7_no_edge_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfg.cap1Sel && (cfg.trig1Edge == 2'b00)) |-> !irqCc1);
endmodule

bind cc_timer cc_timer_chk uChk (
  .clk(clk), .rstN(rstN), .run(strb.run), .cfg(cfg),
  .outPin0(outPin0), .outPin1(outPin1),
  .irqOvf(irqOvf), .irqCc0(irqCc0), .irqCc1(irqCc1)
);

// File: tb/cc_timer_test.sv
module cc_timer_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        tickIn = 1'b1;
  logic        evtPin0 = 1'b0;
  logic        evtPin1 = 1'b0;
  logic        outPin0, outPin1, irqOvf, irqCc0, irqCc1;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  cc_timer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tickIn(tickIn),
    .evtPin0(evtPin0), .evtPin1(evtPin1),
    .outPin0(outPin0), .outPin1(outPin1),
    .irqOvf(irqOvf), .irqCc0(irqCc0), .irqCc1(irqCc1)
  );

  // {channel, compare value, expected edge of the match}
  localparam int VEC [5][3] = '{
    '{0, 1, 1}, '{1, 2, 2}, '{0, 7, 7}, '{1, 100, 100}, '{0, 300, 300}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    rdAddr = 3'(a);
    #1;
    v = int'(rdData);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int v, first, pulses, tog, pulses1, o, prevO;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(a, v);
      chk("R1", "reset register", v, 0);
    end
    chk("R1", "reset outputs", int'({outPin0, outPin1, irqOvf, irqCc0, irqCc1}), 0);

    // R11: readback masks
    wr(2, 16'hFFAB);
    rd(2, v); chk("R11", "config readback", v, 16'h01AB);
    wr(1, 16'hFFFF);
    rd(1, v); chk("R11", "mode readback", v, 7);
    wr(4, 16'h1234);
    rd(4, v); chk("R11", "cc1 load", v, 16'h1234);

    // R5: compare vectors, tickIn high
    for (int i = 0; i < 5; i++) begin
      wr(0, 0); wr(1, 5); wr(2, 0);
      wr(VEC[i][0] == 1 ? 4 : 3, VEC[i][1]);
      wr(0, 1);
      first = -1; pulses = 0; tog = 0;
      prevO = VEC[i][0] == 1 ? int'(outPin1) : int'(outPin0);
      for (int k = 1; k <= VEC[i][1] + 6; k++) begin
        @(negedge clk);
        if ((VEC[i][0] == 1 ? irqCc1 : irqCc0)) begin
          pulses++;
          if (first < 0) first = k;
        end
        o = VEC[i][0] == 1 ? int'(outPin1) : int'(outPin0);
        if (o != prevO) tog++;
        prevO = o;
      end
      chk("R5", "match edge", first, VEC[i][2]);
      chk("R5", "pulse cycles", pulses, 1);
      chk("R5", "output toggles", tog, 1);
    end

    // R2: wrong mode holds counter
    wr(0, 0); wr(2, 0); wr(3, 3); wr(1, 0); wr(0, 1);
    pulses = 0;
    repeat (10) begin @(negedge clk); if (irqCc0 || irqOvf) pulses++; end
    chk("R2", "irq with mode 000", pulses, 0);
    wr(1, 5);
    repeat (3) @(negedge clk);
    chk("R2", "match after mode set", int'(irqCc0), 1);

    // R6: capture on ch1 rising, value N+2 at edge N+3
    wr(0, 0); wr(2, 16'h082); wr(0, 1);
    repeat (10) @(negedge clk);
    evtPin1 = 1'b1;
    @(negedge clk); chk("R6", "irq edge 11", int'(irqCc1), 0);
    @(negedge clk); chk("R6", "irq edge 12", int'(irqCc1), 0);
    @(negedge clk); chk("R6", "irq edge 13", int'(irqCc1), 1);
    rd(4, v); chk("R6", "captured value", v, 12);
    @(negedge clk); chk("R6", "irq edge 14", int'(irqCc1), 0);

    // R7: falling select ignores rising edge
    evtPin1 = 1'b0;
    wr(0, 0); wr(2, 16'h102); wr(0, 1);
    repeat (3) @(negedge clk);
    evtPin1 = 1'b1;
    pulses = 0;
    repeat (6) begin @(negedge clk); if (irqCc1) pulses++; end
    chk("R7", "rise on falling select", pulses, 0);
    rd(4, v); chk("R7", "cc1 untouched", v, 12);
    evtPin1 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "falling capture irq", int'(irqCc1), 1);
    rd(4, v); chk("R7", "falling capture value", v, 11);

    // R7: setting 00 never captures
    wr(2, 16'h002);
    pulses = 0;
    evtPin1 = 1'b1;
    repeat (5) begin @(negedge clk); if (irqCc1) pulses++; end
    evtPin1 = 1'b0;
    repeat (5) begin @(negedge clk); if (irqCc1) pulses++; end
    chk("R7", "no-edge setting irq", pulses, 0);
    rd(4, v); chk("R7", "no-edge cc1 untouched", v, 11);

    // R7/R9: both edges on pin0 into ch0
    wr(0, 0); wr(2, 16'h061); wr(0, 1);
    repeat (4) @(negedge clk);
    evtPin0 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9", "ch0 rise capture irq", int'(irqCc0), 1);
    rd(3, v); chk("R9", "ch0 rise capture", v, 6);
    repeat (3) @(negedge clk);
    evtPin0 = 1'b0;
    repeat (3) @(negedge clk);
    chk("R7", "ch0 fall capture irq", int'(irqCc0), 1);
    rd(3, v); chk("R7", "ch0 fall capture", v, 12);

    // R8/R9/R10: external count on pin0 rising, ch0 captures falling
    wr(0, 0); wr(4, 3); wr(2, 16'h04D); wr(0, 1);
    pulses1 = 0;
    repeat (20) begin @(negedge clk); if (irqCc1) pulses1++; end
    chk("R8", "tickIn ignored", pulses1, 0);
    pulses = 0; tog = 0; prevO = int'(outPin1);
    for (int p = 0; p < 3; p++) begin
      evtPin0 = 1'b1;
      repeat (4) begin
        @(negedge clk);
        if (irqCc0) pulses++;
        if (irqCc1) pulses1++;
        if (int'(outPin1) != prevO) tog++;
        prevO = int'(outPin1);
      end
      evtPin0 = 1'b0;
      repeat (4) begin
        @(negedge clk);
        if (irqCc0) pulses++;
        if (irqCc1) pulses1++;
        if (int'(outPin1) != prevO) tog++;
        prevO = int'(outPin1);
      end
    end
    repeat (6) begin @(negedge clk); if (irqCc0) pulses++; if (irqCc1) pulses1++; end
    chk("R8", "ext count match once", pulses1, 1);
    chk("R8", "ext count toggle", tog, 1);
    chk("R9", "ch0 falling captures", pulses, 3);
    rd(3, v); chk("R9", "ch0 last capture", v, 3);
    chk("R10", "capture ch0 output low", int'(outPin0), 0);

    // R3: disable clears the counter
    wr(0, 0); wr(2, 16'h082); wr(0, 1);
    repeat (20) @(negedge clk);
    wr(0, 0); wr(0, 1);
    repeat (5) @(negedge clk);
    evtPin1 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3", "restart capture irq", int'(irqCc1), 1);
    rd(4, v); chk("R3", "restart from zero", v, 7);
    evtPin1 = 1'b0;

    // R4/R5: wrap and compare value zero
    wr(0, 0); wr(2, 0); wr(3, 0); wr(4, 5); wr(0, 1);
    first = -1; pulses = 0; tog = -1;
    for (int k = 1; k <= 65537; k++) begin
      @(negedge clk);
      if (irqOvf) begin pulses++; if (first < 0) first = k; end
      if (irqCc0 && tog < 0) tog = k;
    end
    chk("R4", "overflow edge", first, 65536);
    chk("R4", "overflow pulses", pulses, 1);
    chk("R5", "zero match at wrap", tog, 65536);

    finishRun();
  end
endmodule